// File: doc/BRIEF.md
# Direct-Sequence Chip Spreader and Correlator

This block performs baseband direct-sequence spreading and despreading at the chip rate. On the transmit side a data bit is taken over a ready/valid handshake. It is then replaced by a run of pseudo-noise chips drawn from a 64-chip code word, and one chip is consumed per `chip_stb` pulse. On the receive side, hard-decision chips arrive one per strobe. A correlator counts how many of them agree with the reference chips over one code period, then turns that count into a data bit, a bit pair, or an erasure.

A 3-bit rate field `{wide32, dual_rate, fine_sample}` selects the variant:
- `000`: full 64-chip symbols carrying one bit.
- `100` and `101`: one 32-chip half of the code word carrying one bit. `half_sel` picks the half, and the sample bit has no effect at chip level.
- `110`: double rate. Both halves are in use and each 32-chip symbol carries two bits.

Every other field value is illegal. It raises `mode_err` and stops all spreading and decoding. Separate transmit and receive inversion controls complement the data on each side. Symbol alignment on receive comes from a start-of-symbol strobe that travels with the first chip.

The transmit FSM has three states. TX_IDLE accepts a bit: it goes to TX_SEND, or to TX_PAIR in double rate. TX_PAIR accepts the second bit and goes to TX_SEND. TX_SEND returns to TX_IDLE on the strobe of the last chip. An illegal mode forces TX_IDLE from any state.

The receive FSM has two states. RX_WAIT goes to RX_ACC on a strobe carrying start-of-symbol. RX_ACC restarts on a new start-of-symbol, and goes back to RX_WAIT on the strobe of the last chip, where it issues the decision. An illegal mode forces RX_WAIT.

Top module: `chip_spread_codec`

## Requirements
- R1: Rate field values 001, 010, 011 and 111 are illegal. While one is applied, `mode_err` is 1, `tx_ready` and `tx_chip_valid` are 0, and no receive result is produced, even if chips with start-of-symbol are supplied. Values 000, 100, 101 and 110 give `mode_err`=0.
- R2: In mode 000 an accepted bit produces 64 chips, one per strobe. Chip k (k=0..63) is `code[k]` when the effective bit is 1 and `~code[k]` when it is 0.
- R3: In modes 100 and 101 an accepted bit produces 32 chips. Chip k is taken from `code[32+k]` when `half_sel`=1 and from `code[k]` when `half_sel`=0, with the same polarity rule as R2. Modes 100 and 101 behave identically.
- R4: In mode 110 two bits are accepted per symbol, and the symbol produces 32 chips. The first bit picks the half (1 = `code[63:32]`, 0 = `code[31:0]`). The second bit sets the polarity as in R2.
- R5: With `tx_inv`=1 every transmitted data bit is complemented before spreading. With `rx_inv`=1 every decided data bit is complemented after despreading. Erasures are not complemented.
- R6: Over one period of length L (64 or 32), let A be the count of chips equal to the reference. A ≥ `thresh` decides 1. Otherwise A ≤ L−`thresh` decides 0. Otherwise `rx_erase`=1 with `rx_data`=00. In single-bit modes the bit is in `rx_data[0]`, `rx_data[1]`=0 and `rx_pair`=0.
- R7: In mode 110 the upper-half count is tested first (≥thresh gives pair 11, ≤L−thresh gives pair 10), then the lower-half count (01, 00). The pair appears as `rx_data[1]`=first bit, `rx_data[0]`=second bit, with `rx_pair`=1.
- R8: Chip counting begins at the strobe that carries `rx_sos`. Strobes without `rx_sos` while waiting are ignored. An `rx_sos` in mid-period restarts the count.
- R9: A result appears on `rx_valid` in the cycle after the clock edge that takes the last chip. It stays valid with stable data while `rx_ready`=0 and no chip strobe arrives, and it clears after a cycle with `rx_ready`=1.
- R10: `tx_ready` is 1 only while waiting for a bit, never while chips are being sent. `tx_chip_valid` is 1 from the cycle after the final bit is accepted until the last chip's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | 3 | {wide32, dual_rate, fine_sample} |
| half_sel | input | 1 | Code half for single-bit 32-chip mode |
| code | input | 64 | Pseudo-noise code word, chip k at bit k |
| tx_inv | input | 1 | Complement transmit data |
| rx_inv | input | 1 | Complement received data |
| thresh | input | 7 | Correlation decision threshold |
| mode_err | output | 1 | Illegal rate field |
| chip_stb | input | 1 | Chip-rate strobe for both directions |
| tx_bit_valid | input | 1 | Transmit bit offered |
| tx_bit | input | 1 | Transmit bit |
| tx_ready | output | 1 | Transmit bit accepted this cycle when valid |
| tx_chip | output | 1 | Current transmit chip |
| tx_chip_valid | output | 1 | A symbol is being sent |
| rx_chip | input | 1 | Received hard-decision chip |
| rx_sos | input | 1 | Start of symbol, with the first chip |
| rx_ready | input | 1 | Consumer takes the result |
| rx_valid | output | 1 | Result available |
| rx_data | output | 2 | Decided bit or bit pair |
| rx_pair | output | 1 | Result carries two bits |
| rx_erase | output | 1 | Count fell in the erasure zone |

## Verification
A wrong chip index or polarity register shows on `tx_chip` at the very strobe where it goes wrong, so the bench compares every chip of every symbol. A stray count or half selection in the correlator stays hidden until the period ends. It then appears one cycle after the last chip as a wrong bit, a wrong pair or a false erasure. Errors are therefore injected close to the threshold, and one pattern lands exactly in the erasure zone. A stuck state shows within one cycle as `tx_ready` and `tx_chip_valid` both high, or as a result that never arrives.

// File: rtl/spread_pkg.sv
package spread_pkg;
    typedef enum logic [1:0] {
        SPAN_FULL  = 2'd0,
        SPAN_HALF  = 2'd1,
        SPAN_DUAL  = 2'd2,
        SPAN_BAD   = 2'd3
    } span_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_PAIR = 2'd1,
        TX_SEND = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_WAIT = 1'b0,
        RX_ACC  = 1'b1
    } rx_state_e;
endpackage

// File: rtl/rate_decode.sv
module rate_decode
    import spread_pkg::*;
(
    input  logic [2:0] rate_sel,
    output span_e      span,
    output logic       bad
);
    always_comb begin
        unique case (rate_sel)
            3'b000:         span = SPAN_FULL;
            3'b100, 3'b101: span = SPAN_HALF;
            3'b110:         span = SPAN_DUAL;
            default:        span = SPAN_BAD;
        endcase
        bad = (span == SPAN_BAD);
    end
endmodule

// File: rtl/chip_spreader.sv
module chip_spreader
    import spread_pkg::*;
#(
    parameter int CODE_LEN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  span_e               span,
    input  logic                bad,
    input  logic                half_sel,
    input  logic [CODE_LEN-1:0] code,
    input  logic                inv,
    input  logic                chip_stb,
    input  logic                in_valid,
    input  logic                in_bit,
    output logic                in_ready,
    output logic                chip,
    output logic                chip_valid
);
    localparam int IDX_W = $clog2(CODE_LEN);
    localparam int HALF  = CODE_LEN / 2;

    tx_state_e        state, state_nx;
    logic [IDX_W-1:0] idx;
    logic             upper;
    logic             pol;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] sel;
    logic             take;
    logic             eff;

    assign last_idx = (span == SPAN_FULL) ? IDX_W'(CODE_LEN - 1) : IDX_W'(HALF - 1);
    assign sel      = upper ? (IDX_W'(HALF) + idx) : idx;
    assign eff      = in_bit ^ inv;
    assign take     = in_valid && in_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE: if (take) state_nx = (span == SPAN_DUAL) ? TX_PAIR : TX_SEND;
            TX_PAIR: if (take) state_nx = TX_SEND;
            TX_SEND: if (chip_stb && idx == last_idx) state_nx = TX_IDLE;
            default: state_nx = TX_IDLE;
        endcase
        if (bad) state_nx = TX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            upper <= 1'b0;
            pol   <= 1'b0;
        end else if (state == TX_IDLE && take) begin
            idx   <= '0;
            pol   <= eff;
            upper <= (span == SPAN_DUAL) ? eff : ((span == SPAN_HALF) && half_sel);
        end else if (state == TX_PAIR && take) begin
            pol   <= eff;
        end else if (state == TX_SEND && chip_stb) begin
            idx   <= idx + 1'b1;
        end
    end

    always_comb begin
        in_ready   = !bad && (state == TX_IDLE || state == TX_PAIR);
        chip_valid = (state == TX_SEND);
        chip       = chip_valid && !(code[sel] ^ pol);
    end
endmodule

// File: rtl/chip_correlator.sv
module chip_correlator
    import spread_pkg::*;
#(
    parameter int CODE_LEN = 64,
    parameter int CNT_W    = $clog2(CODE_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  span_e               span,
    input  logic                bad,
    input  logic                half_sel,
    input  logic [CODE_LEN-1:0] code,
    input  logic                inv,
    input  logic [CNT_W-1:0]    thresh,
    input  logic                chip_stb,
    input  logic                chip,
    input  logic                sos,
    input  logic                out_ready,
    output logic                out_valid,
    output logic [1:0]          out_data,
    output logic                out_pair,
    output logic                out_erase
);
    localparam int IDX_W = $clog2(CODE_LEN);
    localparam int HALF  = CODE_LEN / 2;

    rx_state_e        state, state_nx;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt_a, cnt_b, tot_a, tot_b, len_c, low_lim;
    logic [IDX_W-1:0] last_idx, pos, sel_a, sel_b;
    logic             agree_a, agree_b, start, finish;
    logic [3:0]       verdict;

    assign last_idx = (span == SPAN_FULL) ? IDX_W'(CODE_LEN - 1) : IDX_W'(HALF - 1);
    assign len_c    = (span == SPAN_FULL) ? CNT_W'(CODE_LEN) : CNT_W'(HALF);
    assign low_lim  = len_c - thresh;
    assign start    = !bad && chip_stb && sos;
    assign finish   = !bad && chip_stb && !sos && state == RX_ACC && idx == last_idx;
    assign pos      = sos ? '0 : idx;
    assign sel_a    = ((span == SPAN_HALF) && half_sel) ? (IDX_W'(HALF) + pos) : pos;
    assign sel_b    = IDX_W'(HALF) + pos;
    assign agree_a  = (chip == code[sel_a]);
    assign agree_b  = (chip == code[sel_b]);
    assign tot_a    = cnt_a + CNT_W'(agree_a);
    assign tot_b    = cnt_b + CNT_W'(agree_b);

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_WAIT: if (start) state_nx = RX_ACC;
            RX_ACC:  if (finish) state_nx = RX_WAIT;
            default: state_nx = RX_WAIT;
        endcase
        if (bad) state_nx = RX_WAIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_WAIT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            cnt_a <= '0;
            cnt_b <= '0;
        end else if (start) begin
            idx   <= IDX_W'(1);
            cnt_a <= CNT_W'(agree_a);
            cnt_b <= CNT_W'(agree_b);
        end else if (chip_stb && state == RX_ACC) begin
            idx   <= idx + 1'b1;
            cnt_a <= tot_a;
            cnt_b <= tot_b;
        end
    end

    // verdict = {erase, pair, first, second}
    always_comb begin
        verdict = 4'b1000;
        if (span == SPAN_DUAL) begin
            if      (tot_b >= thresh)  verdict = {2'b01, 1'b1 ^ inv, 1'b1 ^ inv};
            else if (tot_b <= low_lim) verdict = {2'b01, 1'b1 ^ inv, 1'b0 ^ inv};
            else if (tot_a >= thresh)  verdict = {2'b01, 1'b0 ^ inv, 1'b1 ^ inv};
            else if (tot_a <= low_lim) verdict = {2'b01, 1'b0 ^ inv, 1'b0 ^ inv};
            else                       verdict = 4'b1100;
        end else begin
            if      (tot_a >= thresh)  verdict = {3'b000, 1'b1 ^ inv};
            else if (tot_a <= low_lim) verdict = {3'b000, 1'b0 ^ inv};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= 2'b00;
            out_pair  <= 1'b0;
            out_erase <= 1'b0;
        end else if (bad) begin
            out_valid <= 1'b0;
        end else if (finish) begin
            out_valid <= 1'b1;
            out_erase <= verdict[3];
            out_pair  <= verdict[2];
            out_data  <= verdict[1:0];
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/chip_spread_codec.sv
module chip_spread_codec
    import spread_pkg::*;
#(
    parameter int CODE_LEN = 64,
    parameter int CNT_W    = $clog2(CODE_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          rate_sel,
    input  logic                half_sel,
    input  logic [CODE_LEN-1:0] code,
    input  logic                tx_inv,
    input  logic                rx_inv,
    input  logic [CNT_W-1:0]    thresh,
    output logic                mode_err,
    input  logic                chip_stb,
    input  logic                tx_bit_valid,
    input  logic                tx_bit,
    output logic                tx_ready,
    output logic                tx_chip,
    output logic                tx_chip_valid,
    input  logic                rx_chip,
    input  logic                rx_sos,
    input  logic                rx_ready,
    output logic                rx_valid,
    output logic [1:0]          rx_data,
    output logic                rx_pair,
    output logic                rx_erase
);
    span_e span;

    rate_decode u_dec (
        .rate_sel (rate_sel),
        .span     (span),
        .bad      (mode_err)
    );

    chip_spreader #(.CODE_LEN(CODE_LEN)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .span       (span),
        .bad        (mode_err),
        .half_sel   (half_sel),
        .code       (code),
        .inv        (tx_inv),
        .chip_stb   (chip_stb),
        .in_valid   (tx_bit_valid),
        .in_bit     (tx_bit),
        .in_ready   (tx_ready),
        .chip       (tx_chip),
        .chip_valid (tx_chip_valid)
    );

    chip_correlator #(.CODE_LEN(CODE_LEN), .CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .span      (span),
        .bad       (mode_err),
        .half_sel  (half_sel),
        .code      (code),
        .inv       (rx_inv),
        .thresh    (thresh),
        .chip_stb  (chip_stb),
        .chip      (rx_chip),
        .sos       (rx_sos),
        .out_ready (rx_ready),
        .out_valid (rx_valid),
        .out_data  (rx_data),
        .out_pair  (rx_pair),
        .out_erase (rx_erase)
    );
endmodule

// File: rtl/chip_spread_codec_chk.sv
module chip_spread_codec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_err,
    input logic       chip_stb,
    input logic       tx_ready,
    input logic       tx_chip_valid,
    input logic       rx_ready,
    input logic       rx_valid,
    input logic [1:0] rx_data,
    input logic       rx_erase
);
    p_err_blocks_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (!tx_ready && !tx_chip_valid));

    p_err_no_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> !rx_valid);

    p_erase_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_erase) |-> (rx_data == 2'b00));

    p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && !chip_stb && !mode_err) |=> (rx_valid && $stable(rx_data)));

    p_ready_not_sending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !tx_chip_valid);
endmodule

bind chip_spread_codec chip_spread_codec_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_err      (mode_err),
    .chip_stb      (chip_stb),
    .tx_ready      (tx_ready),
    .tx_chip_valid (tx_chip_valid),
    .rx_ready      (rx_ready),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rx_erase      (rx_erase)
);

// File: tb/chip_spread_codec_bench.sv
`timescale 1ns/1ps
module chip_spread_codec_bench;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  rate_sel = 3'b000;
    logic        half_sel = 0;
    logic [63:0] code;
    logic        tx_inv = 0, rx_inv = 0;
    logic [6:0]  thresh = 7'd52;
    logic        mode_err;
    logic        chip_stb = 0;
    logic        tx_bit_valid = 0, tx_bit = 0;
    logic        tx_ready, tx_chip, tx_chip_valid;
    logic        rx_chip = 0, rx_sos = 0, rx_ready = 1;
    logic        rx_valid;
    logic [1:0]  rx_data;
    logic        rx_pair, rx_erase;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic rxc [64];

    always #2.5 clk = ~clk;

    chip_spread_codec u_chip_spread_codec (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .half_sel(half_sel), .code(code),
        .tx_inv(tx_inv), .rx_inv(rx_inv), .thresh(thresh), .mode_err(mode_err),
        .chip_stb(chip_stb), .tx_bit_valid(tx_bit_valid), .tx_bit(tx_bit),
        .tx_ready(tx_ready), .tx_chip(tx_chip), .tx_chip_valid(tx_chip_valid),
        .rx_chip(rx_chip), .rx_sos(rx_sos), .rx_ready(rx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_pair(rx_pair), .rx_erase(rx_erase)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int kind_of(input logic [2:0] r);
        if (r == 3'b000) return 0;
        if (r == 3'b100 || r == 3'b101) return 1;
        if (r == 3'b110) return 2;
        return 3;
    endfunction

    // every clock, shortly after the edge: legality flag and handshake exclusivity
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(mode_err == (kind_of(rate_sel) == 3), "R1 mode_err", mode_err, kind_of(rate_sel) == 3);
            chk(!(tx_ready && tx_chip_valid), "R10 ready while sending", tx_ready, 0);
        end
    end

    // Send one symbol through the spreader, loop chips back with nerr flipped chips,
    // and check both the chips and the decision against a behavioural model.
    task automatic symbol(input logic [1:0] bits, input int nerr, input string req);
        int kind = kind_of(rate_sel);
        int len = (kind == 0) ? 64 : 32;
        logic [1:0] eb = bits ^ {tx_inv, tx_inv};
        bit up = (kind == 2) ? eb[1] : (kind == 1 && half_sel);
        bit pol = eb[0];
        int bad_chips = 0;
        int aga = 0, agb = 0;
        int lim;
        logic [3:0] exp_v;
        @(negedge clk);
        tx_bit_valid = 1;
        tx_bit = (kind == 2) ? bits[1] : bits[0];
        chk(tx_ready == 1, {req, " R10 ready idle"}, tx_ready, 1);
        if (kind == 2) begin
            @(negedge clk);
            tx_bit = bits[0];
            chk(tx_ready == 1, {req, " R4 ready for second bit"}, tx_ready, 1);
        end
        @(negedge clk);
        tx_bit_valid = 0;
        chk(tx_chip_valid == 1 && tx_ready == 0, {req, " R10 sending"}, tx_chip_valid, 1);
        for (int k = 0; k < len; k++) begin
            logic expc = pol ? code[(up ? 32 : 0) + k] : ~code[(up ? 32 : 0) + k];
            if (tx_chip !== expc) bad_chips++;
            rxc[k] = tx_chip ^ (k < nerr);
            rx_chip = rxc[k];
            rx_sos = (k == 0);
            chip_stb = 1;
            @(negedge clk);
        end
        chip_stb = 0;
        rx_sos = 0;
        chk(bad_chips == 0, {req, " chip sequence"}, bad_chips, 0);
        // model of the decision
        for (int k = 0; k < len; k++) begin
            int ra = (kind == 1 && half_sel) ? 32 + k : k;
            if (rxc[k] == code[ra]) aga++;
            if (rxc[k] == code[32 + k]) agb++;
        end
        lim = len - int'(thresh);
        exp_v = 4'b1000;
        if (kind == 2) begin
            if      (agb >= thresh) exp_v = {2'b01, ~rx_inv, ~rx_inv};
            else if (agb <= lim)    exp_v = {2'b01, ~rx_inv, rx_inv};
            else if (aga >= thresh) exp_v = {2'b01, rx_inv, ~rx_inv};
            else if (aga <= lim)    exp_v = {2'b01, rx_inv, rx_inv};
            else                    exp_v = 4'b1100;
        end else begin
            if      (aga >= thresh) exp_v = {3'b000, ~rx_inv};
            else if (aga <= lim)    exp_v = {3'b000, rx_inv};
        end
        chk(rx_valid == 1, {req, " R9 result valid"}, rx_valid, 1);
        chk({rx_erase, rx_pair, rx_data} == exp_v, {req, " R6 decision"},
            int'({rx_erase, rx_pair, rx_data}), int'(exp_v));
        if (kind != 2 && !exp_v[3])
            chk(rx_data[0] == (bits[0] ^ tx_inv ^ rx_inv), {req, " recovered bit"}, rx_data[0], bits[0] ^ tx_inv ^ rx_inv);
        if (kind == 2)
            chk(rx_data == (bits ^ {2{tx_inv ^ rx_inv}}), {req, " R7 recovered pair"}, rx_data, bits ^ {2{tx_inv ^ rx_inv}});
        chk(tx_chip_valid == 0, {req, " R10 idle after symbol"}, tx_chip_valid, 0);
    endtask

    initial begin
        code = {32'h3C5A_96E1 ^ 32'h0000_FFFF, 32'h3C5A_96E1};
        repeat (3) @(negedge clk);
        chk(tx_ready == 1 && tx_chip_valid == 0 && rx_valid == 0 && mode_err == 0,
            "reset state", {tx_ready, tx_chip_valid, rx_valid, mode_err}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(tx_ready == 1 && rx_valid == 0, "R10 reset ready", tx_ready, 1);

        // R2: full 64-chip symbols
        rate_sel = 3'b000; thresh = 52;
        symbol(2'b01, 3, "R2 bit1");
        symbol(2'b00, 5, "R2 bit0");
        half_sel = 1;
        symbol(2'b01, 0, "R2 half_sel ignored");
        half_sel = 0;

        // R3: half-code single bit
        rate_sel = 3'b100; thresh = 26;
        symbol(2'b01, 2, "R3 lower bit1");
        symbol(2'b00, 2, "R3 lower bit0");
        half_sel = 1;
        symbol(2'b01, 3, "R3 upper bit1");
        rate_sel = 3'b101;
        symbol(2'b00, 4, "R3 sample bit no effect");
        half_sel = 0;

        // R4 / R7: dual rate, all pairs
        rate_sel = 3'b110;
        symbol(2'b00, 2, "R4 pair00");
        symbol(2'b01, 2, "R4 pair01");
        symbol(2'b10, 2, "R7 pair10");
        symbol(2'b11, 3, "R7 pair11");

        // R5: inversion controls
        rate_sel = 3'b100;
        tx_inv = 1; rx_inv = 1;
        symbol(2'b01, 1, "R5 both inverted");
        rx_inv = 0;
        symbol(2'b01, 1, "R5 tx only");
        tx_inv = 0; rx_inv = 1;
        symbol(2'b00, 1, "R5 rx only");
        rate_sel = 3'b110; tx_inv = 1;
        symbol(2'b10, 1, "R5 dual inverted");
        tx_inv = 0; rx_inv = 0;

        // R6: erasure zone (agreement exactly 16 of 32)
        rate_sel = 3'b100;
        symbol(2'b01, 16, "R6 erasure");
        chk(rx_erase == 1, "R6 erase flag", rx_erase, 1);

        // R8: stray chips before sos, and a restart in mid-period
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); chip_stb = 1; rx_sos = 0; rx_chip = k[0];
        end
        @(negedge clk); chip_stb = 0;
        chk(rx_valid == 0, "R8 no result without sos", rx_valid, 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); chip_stb = 1; rx_sos = (k == 0); rx_chip = ~code[k];
        end
        @(negedge clk); chip_stb = 0; rx_sos = 0;
        symbol(2'b01, 2, "R8 restart on sos");

        // R9: hold while not ready
        rx_ready = 0;
        symbol(2'b00, 1, "R9 hold");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(rx_valid == 1 && rx_data == 2'b00, "R9 held", rx_valid, 1);
        end
        rx_ready = 1;
        @(negedge clk);
        @(negedge clk);
        chk(rx_valid == 0, "R9 cleared after ready", rx_valid, 0);

        // R1: illegal fields
        foreach (rxc[i]) rxc[i] = 0;
        for (int m = 0; m < 4; m++) begin
            logic [2:0] badv = (m == 0) ? 3'b001 : (m == 1) ? 3'b010 : (m == 2) ? 3'b011 : 3'b111;
            @(negedge clk);
            rate_sel = badv;
            tx_bit_valid = 1; tx_bit = 1;
            @(negedge clk);
            chk(mode_err == 1 && tx_ready == 0, "R1 illegal blocks tx", {mode_err, tx_ready}, 2);
            for (int k = 0; k < 32; k++) begin
                chip_stb = 1; rx_sos = (k == 0); rx_chip = code[k];
                @(negedge clk);
                if (tx_chip_valid) chk(0, "R1 chips sent in illegal mode", 1, 0);
            end
            chip_stb = 0; rx_sos = 0;
            @(negedge clk);
            chk(rx_valid == 0 && tx_chip_valid == 0, "R1 no result", rx_valid, 0);
        end
        tx_bit_valid = 0;
        rate_sel = 3'b100;
        symbol(2'b01, 0, "R1 recovery");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule